// File: doc/BRIEF.md
# Parameterised Code-Pair Transposition Gate

This block is a reversible permutation of an N-bit data word together with a bank of scratch lines. It exchanges two chosen N-bit codes, `CODE_A` and `CODE_B`. The two codes must differ in exactly one bit position, and that position becomes the target line. Every other input code appears unchanged at the output. The scratch lines always come back with the values they went in with, whatever those values were.

Internally, a wide multi-control toggle is built as a cascade of three-line Toffoli stages. Each stage computes `z <= z ^ (x & y)` and is its own inverse. The cascade treats the scratch lines as borrowed, so their starting values may be anything. It has 4·(N−3) stages. The triggering control pattern is fixed by inverting, before and after the cascade, every control line whose bit in `CODE_A` is 0.

The result is captured in one output register stage. `N`, `CODE_A` and `CODE_B` are fixed at elaboration. Elaboration stops with an error if N < 4 or if the codes do not differ in exactly one bit.

Top module: `tg_transposer`

## Requirements
- R1: When `data_i` equals `CODE_A`, `data_o` equals `CODE_B` one clock edge later.
- R2: When `data_i` equals `CODE_B`, `data_o` equals `CODE_A` one clock edge later.
- R3: Any `data_i` other than the two chosen codes appears unchanged on `data_o` one clock edge later.
- R4: `scratch_o` equals the `scratch_i` of the previous edge for every combination of data and scratch input, including nonzero scratch values.
- R5: Feeding `data_o` back into `data_i` returns the original code, so applying the gate twice is the identity.
- R6: While `rst_n` is low, `data_o` and `scratch_o` are all zeros. Results appear exactly one rising edge after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low; clears the outputs |
| data_i | input | N | Data word to permute |
| scratch_i | input | N-3 | Borrowed scratch lines, any value |
| data_o | output | N | Permuted data word, registered |
| scratch_o | output | N-3 | Scratch lines returned, registered |

## Verification
The bench drives every pairing of data code and scratch value through an instance with non-trivial control polarity, N = 5, and two scratch lines. A cascade that does not restore a dirty scratch line shows up as a `scratch_o` mismatch when `scratch_i` is nonzero. A wrong polarity mask swaps the wrong pair, so `CODE_A` or `CODE_B` comes out unchanged, or a neighbouring code gets altered. A loop-back pass feeds each output back in. An asymmetric mapping, for example one that moves a third code, fails to return the starting word. Nonzero inputs are held during reset to catch outputs that leave zero early.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef struct packed {
        int ca;
        int cb;
        int tg;
    } stage_t;

    // Position of the i-th control line among the data bits (target skipped)
    function automatic int ctrl_pos(int tgt, int i);
        return (i < tgt) ? i : i + 1;
    endfunction

    // Lowest set bit of a difference word, or -1 when none
    function automatic int first_one(logic [63:0] v, int n);
        for (int i = 0; i < n; i++) begin
            if (v[i]) return i;
        end
        return -1;
    endfunction

    // Polarity mask: control lines whose bit in code a is 0 get inverted
    function automatic logic [63:0] pol_mask(logic [63:0] a, int n, int tgt);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            if (i != tgt) m[i] = ~a[i];
        end
        return m;
    endfunction

    // Stage s of the borrowed-scratch ladder for k = n-1 controls.
    // Scratch line j sits at vector index n + j.
    function automatic stage_t stage_at(int n, int tgt, int s);
        stage_t st;
        int k;
        int first_len;
        int pos;
        int lim;
        int top;
        int m;
        k         = n - 1;
        first_len = 2 * (k - 2) + 1;
        if (s < first_len) begin
            pos = s;
            lim = k - 2;
            top = k - 1;
        end else begin
            pos = s - first_len;
            lim = k - 3;
            top = k - 2;
        end
        if (pos == lim) begin
            st.ca = ctrl_pos(tgt, 0);
            st.cb = ctrl_pos(tgt, 1);
            st.tg = n;
        end else begin
            m     = (pos < lim) ? (top - pos) : (2 + (pos - lim - 1));
            st.ca = ctrl_pos(tgt, m);
            st.cb = n + m - 2;
            st.tg = (m == k - 1) ? tgt : (n + m - 1);
        end
        return st;
    endfunction

endpackage

// File: rtl/tg_polarity.sv
module tg_polarity #(
    parameter int          W    = 5,
    parameter logic [W-1:0] MASK = '0
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);
    always_comb begin
        vec_o = vec_i ^ MASK;
    end
endmodule

// File: rtl/tg_stage.sv
module tg_stage #(
    parameter int W  = 5,
    parameter int CA = 0,
    parameter int CB = 1,
    parameter int TG = 2
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);
    always_comb begin
        vec_o     = vec_i;
        vec_o[TG] = vec_i[TG] ^ (vec_i[CA] & vec_i[CB]);
    end
endmodule

// File: rtl/tg_transposer.sv
module tg_transposer
    import tg_pkg::*;
#(
    parameter int           N      = 4,
    parameter logic [N-1:0] CODE_A = 4'b0100,
    parameter logic [N-1:0] CODE_B = 4'b0101
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   data_i,
    input  logic [N-4:0]   scratch_i,
    output logic [N-1:0]   data_o,
    output logic [N-4:0]   scratch_o
);
    localparam int           NS   = N - 3;
    localparam int           W    = N + NS;
    localparam int           NSTG = 4 * NS;
    localparam logic [N-1:0] DIFF = CODE_A ^ CODE_B;
    localparam int           TGT  = first_one(64'(DIFF), N);
    localparam logic [63:0]  PM64 = pol_mask(64'(CODE_A), N, TGT);
    localparam logic [W-1:0] PMASK = PM64[W-1:0];

    if (N < 4) begin : g_bad_width
        $error("tg_transposer: N must be at least 4");
    end
    if ($countones(DIFF) != 1) begin : g_bad_pair
        $error("tg_transposer: codes must differ in exactly one bit");
    end

    typedef struct packed {
        logic [N-1:0]  data;
        logic [NS-1:0] scr;
    } out_t;

    logic [W-1:0] pre_vec;
    logic [W-1:0] post_vec;
    logic [W-1:0] chain [NSTG+1];

    tg_polarity #(.W(W), .MASK(PMASK)) u_pol_in (
        .vec_i ({scratch_i, data_i}),
        .vec_o (pre_vec)
    );

    assign chain[0] = pre_vec;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        localparam stage_t ST = stage_at(N, TGT, g);
        tg_stage #(.W(W), .CA(ST.ca), .CB(ST.cb), .TG(ST.tg)) u_stage (
            .vec_i (chain[g]),
            .vec_o (chain[g+1])
        );
    end

    tg_polarity #(.W(W), .MASK(PMASK)) u_pol_out (
        .vec_i (chain[NSTG]),
        .vec_o (post_vec)
    );

    out_t out_d, out_q;

    always_comb begin
        out_d.data = post_vec[N-1:0];
        out_d.scr  = post_vec[W-1:N];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign data_o    = out_q.data;
    assign scratch_o = out_q.scr;

    assert_swap_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (data_i == CODE_A) |=> (data_o == CODE_B));

    assert_swap_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_i == CODE_B) |=> (data_o == CODE_A));

    assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_i != CODE_A && data_i != CODE_B) |=> (data_o == $past(data_i)));

    assert_scratch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (scratch_o == $past(scratch_i)));

    assert_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(data_o ^ $past(data_i)) <= 1));

endmodule

// File: tb/tb_tg_transposer.sv
module tb_tg_transposer;
    localparam int           N   = 5;
    localparam int           NS  = N - 3;
    localparam logic [N-1:0] CA  = 5'b10110;
    localparam logic [N-1:0] CB  = 5'b10010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  data_i = '0;
    logic [NS-1:0] scratch_i = '0;
    logic [N-1:0]  data_o;
    logic [NS-1:0] scratch_o;

    int total = 0;
    int bad = 0;
    logic drv_live = 1'b0;
    logic [N+NS-1:0] expq [$];

    always #10 clk = ~clk;

    tg_transposer #(.N(N), .CODE_A(CA), .CODE_B(CB)) dut (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .scratch_i(scratch_i),
        .data_o(data_o), .scratch_o(scratch_o)
    );

    function automatic logic [N-1:0] model(logic [N-1:0] x);
        if (x == CA) return CB;
        if (x == CB) return CA;
        return x;
    endfunction

    function automatic string req_of(logic [N-1:0] x);
        if (x == CA) return "R1";
        if (x == CB) return "R2";
        return "R3";
    endfunction

    task automatic check(string req, logic [N+NS-1:0] act, logic [N+NS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(logic [N-1:0] d, logic [NS-1:0] s);
        @(negedge clk);
        data_i    = d;
        scratch_i = s;
        drv_live  = 1'b1;
        expq.push_back({s, model(d)});
    endtask

    // Monitor: the result of the inputs held at an edge is sampled mid-high phase
    initial begin
        forever begin
            logic cap;
            logic [N+NS-1:0] e;
            @(posedge clk);
            cap = drv_live;
            #5;
            if (cap && expq.size() > 0) begin
                e = expq.pop_front();
                if (e[N-1:0] == CA || e[N-1:0] == CB || e[N-1:0] != model(e[N-1:0])) begin
                    check((e[N-1:0] == CB) ? "R1" : (e[N-1:0] == CA) ? "R2" : "R3",
                          {scratch_o, data_o}, e);
                end else begin
                    check("R3", {scratch_o, data_o}, e);
                end
                check("R4", {{N{1'b0}}, scratch_o}, {{N{1'b0}}, e[N+NS-1:N]});
            end
        end
    end

    initial begin
        #4000000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R6: reset holds outputs at zero even with nonzero inputs
        data_i = CA;
        scratch_i = '1;
        repeat (3) @(posedge clk);
        #5;
        check("R6", {scratch_o, data_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 latency: result appears after exactly one edge
        @(negedge clk);
        data_i = 5'b00011;
        scratch_i = 2'b01;
        @(posedge clk);
        #5;
        check("R6", {scratch_o, data_o}, {2'b01, 5'b00011});

        // R1 R2 R3 R4: every data code with every scratch value
        for (int s = 0; s < (1 << NS); s++) begin
            for (int d = 0; d < (1 << N); d++) begin
                drive(N'(d), NS'(s));
            end
        end
        @(negedge clk);
        drv_live = 1'b0;
        @(posedge clk);
        #6;

        // R5: loop output back, expect the original code
        for (int d = 0; d < (1 << N); d++) begin
            logic [N-1:0] y;
            @(negedge clk);
            data_i = N'(d);
            scratch_i = 2'b10;
            @(posedge clk);
            #5;
            y = data_o;
            @(negedge clk);
            data_i = y;
            @(posedge clk);
            #5;
            check("R5", {{NS{1'b0}}, data_o}, {{NS{1'b0}}, N'(d)});
        end

        // R6: asserting reset again clears the outputs
        @(negedge clk);
        data_i = CB;
        rst_n = 1'b0;
        #5;
        check("R6", {scratch_o, data_o}, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule